// File: doc/BRIEF.md
# Pattern-Unlocked Serial Clock Register Port

This block is a concealed one-bit serial port for a battery-backed calendar clock that shares a memory socket with ordinary storage. Each access cycle (`acc_i` high at a rising clock edge) carries one data bit and a direction select. The port stays invisible until a 64-bit unlock key arrives, one bit per access. After the key, the next 64 accesses move the contents of eight 8-bit clock registers in or out, one bit at a time.

The day register (register 3) holds two control bits. Bit 4 decides whether an active-low external pin can abort an access in progress. Bit 5 stops the oscillator: while it is set, time is frozen. A one-pulse-per-second tick input stands in for the calendar logic. Each tick adds one to the seconds register in BCD and carries into the minutes register.

Top module: `serial_clock_port`

## Requirements
- R1: After reset every register reads 0x00 except the day register (index 3), which reads 0x20: bit 5 (oscillator off) is 1 and bit 4 (pin abort ignored) is 0.
- R2: The port unlocks only after 64 consecutive write accesses (`rd_i` low) whose bits match 64'h5CA33AC55CA33AC5, taken bit 0 first. A mismatching bit, or a read access, returns matching to key bit 0.
- R3: In a read transfer, during data access k (k = 0..63), `dout_en_o` is 1 and `dout_o` shows bit k of the register image. In that image, register i fills bits 8i..8i+7 with its bit 0 lowest. The image is captured on the edge that completes the key, so ticks during the transfer do not affect it.
- R4: In a write transfer, data access k supplies image bit k. All eight registers change together, on the edge of the 64th data access, and not before.
- R5: The `rd_i` value of the first data access fixes the direction of the whole transfer. `rd_i` in later data accesses is ignored, and `data_i` is ignored during reads.
- R6: After the 64th data access the port goes back to key matching at bit 0. `dout_en_o` is 0 outside a read transfer.
- R7: While day bit 4 is 0, `rst_pin_ni` low at a clock edge aborts recognition or transfer. No register changes, and the next access is treated as key bit 0.
- R8: While day bit 4 is 1, `rst_pin_ni` has no effect on recognition or transfer.
- R9: While day bit 5 is 0, a tick advances seconds (register 0) in BCD from 00 to 59. The step from 59 to 00 advances minutes (register 1) in BCD, and minutes wrap from 59 to 00 with no further carry.
- R10: While day bit 5 is 1, ticks leave every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_i | input | 1 | Access strobe, one bit transferred per sampled cycle |
| rd_i | input | 1 | Direction of the access: 1 read, 0 write |
| data_i | input | 1 | Serial data bit for key or write |
| rst_pin_ni | input | 1 | External abort pin, active low, gated by day bit 4 |
| tick_i | input | 1 | One-pulse-per-second time tick |
| dout_o | output | 1 | Serial read data bit |
| dout_en_o | output | 1 | High while a read transfer drives `dout_o` |

## Verification
Read data is combinational from the snapshot: `dout_o` for an access is due in the same cycle as that access. The bench drives each access at a falling edge and samples 1 ns later, before the rising edge that consumes it. A write commit and a tick each take effect on the rising edge they are sampled at. An abort takes effect on the edge where the pin is seen low. None of these effects is observed directly. The bench reads them back later through a full unlock-and-read sequence, so every check compares a 64-bit image that the bench builds from BCD arithmetic and its own model of the register contents.

// File: rtl/scp_pkg.sv
package scp_pkg;

  typedef enum logic {
    PH_MATCH = 1'b0,
    PH_XFER  = 1'b1
  } phase_e;

  // BCD modulo-60 increment, returns {carry, next}
  function automatic logic [8:0] bcd60_inc(input logic [7:0] v);
    logic [3:0] lo;
    logic [3:0] hi;
    lo = v[3:0];
    hi = v[7:4];
    if (lo >= 4'd9) begin
      lo = 4'd0;
      if (hi >= 4'd5) return 9'h100;
      hi = hi + 4'd1;
    end else begin
      lo = lo + 4'd1;
    end
    return {1'b0, hi, lo};
  endfunction

endpackage

// File: rtl/scp_matcher.sv
module scp_matcher #(
  parameter int          KEY_W = 64,
  parameter logic [63:0] KEY   = 64'h5CA33AC55CA33AC5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic rd_i,
  input  logic bit_i,
  output logic done_o
);
  localparam int CW = $clog2(KEY_W);

  logic [CW-1:0] idx_q;
  logic          hit;

  assign hit    = en_i & ~rd_i & (bit_i == KEY[idx_q]);
  assign done_o = hit & (idx_q == CW'(KEY_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         idx_q <= '0;
    else if (clr_i)      idx_q <= '0;
    else if (en_i) begin
      if (hit && !done_o) idx_q <= idx_q + 1'b1;
      else                idx_q <= '0;
    end
  end
endmodule

// File: rtl/scp_sequencer.sv
module scp_sequencer
  import scp_pkg::*;
#(
  parameter int XFER_BITS = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic start_i,
  input  logic acc_i,
  input  logic rd_i,
  output logic busy_o,
  output logic rd_mode_o,
  output logic shift_o,
  output logic last_o
);
  localparam int CW = $clog2(XFER_BITS);

  phase_e        ph_q;
  logic [CW-1:0] cnt_q;
  logic          first_q;
  logic          dir_q;

  assign busy_o    = (ph_q == PH_XFER);
  assign rd_mode_o = first_q ? rd_i : dir_q;
  assign shift_o   = busy_o & acc_i;
  assign last_o    = shift_o & (cnt_q == CW'(XFER_BITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_MATCH;
      cnt_q   <= '0;
      first_q <= 1'b0;
      dir_q   <= 1'b0;
    end else if (clr_i) begin
      ph_q    <= PH_MATCH;
      cnt_q   <= '0;
      first_q <= 1'b0;
    end else if (start_i) begin
      ph_q    <= PH_XFER;
      cnt_q   <= '0;
      first_q <= 1'b1;
    end else if (shift_o) begin
      first_q <= 1'b0;
      if (first_q) dir_q <= rd_i;
      cnt_q <= cnt_q + 1'b1;
      if (last_o) ph_q <= PH_MATCH;
    end
  end
endmodule

// File: rtl/scp_regfile.sv
module scp_regfile
  import scp_pkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int REG_W       = 8,
  parameter int DAY_IDX     = 3,
  parameter int RST_EN_BIT  = 4,
  parameter int OSC_OFF_BIT = 5
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic                      shift_i,
  input  logic                      rd_mode_i,
  input  logic                      bit_i,
  input  logic                      commit_i,
  input  logic                      tick_i,
  output logic                      dout_o,
  output logic                      pin_en_o,
  output logic                      osc_on_o,
  output logic [NUM_REGS*REG_W-1:0] regs_o
);
  localparam int                TOT       = NUM_REGS * REG_W;
  localparam logic [REG_W-1:0]  DAY_INIT  = REG_W'(1) << OSC_OFF_BIT;
  localparam logic [TOT-1:0]    RESET_IMG = TOT'(DAY_INIT) << (DAY_IDX * REG_W);

  logic [TOT-1:0]   regs_q, regs_d;
  logic [TOT-1:0]   snap_q;
  logic [TOT-1:0]   shadow_q;
  logic [TOT-1:0]   wr_img;
  logic [REG_W-1:0] day;
  logic [REG_W-1:0] reg_view [NUM_REGS];
  logic [8:0]       sec_inc, min_inc;

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_view
      assign reg_view[g] = regs_q[g*REG_W +: REG_W];
    end
  endgenerate

  assign day      = reg_view[DAY_IDX];
  assign pin_en_o = ~day[RST_EN_BIT];
  assign osc_on_o = ~day[OSC_OFF_BIT];
  assign regs_o   = regs_q;
  assign dout_o   = snap_q[0];
  assign wr_img   = {bit_i, shadow_q[TOT-1:1]};
  assign sec_inc  = bcd60_inc(reg_view[0][7:0]);
  assign min_inc  = bcd60_inc(reg_view[1][7:0]);

  always_comb begin
    regs_d = regs_q;
    if (commit_i) begin
      regs_d = wr_img;
    end else if (tick_i && osc_on_o) begin
      regs_d[7:0] = sec_inc[7:0];
      if (sec_inc[8]) regs_d[REG_W +: 8] = min_inc[7:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) regs_q <= RESET_IMG;
    else         regs_q <= regs_d;
  end

  // Snapshot isolates a read from ticks during the transfer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   snap_q <= '0;
    else if (load_i)               snap_q <= regs_q;
    else if (shift_i && rd_mode_i) snap_q <= {1'b0, snap_q[TOT-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    shadow_q <= '0;
    else if (shift_i && !rd_mode_i) shadow_q <= wr_img;
  end
endmodule

// File: rtl/serial_clock_port.sv
module serial_clock_port #(
  parameter int          NUM_REGS    = 8,
  parameter int          REG_W       = 8,
  parameter int          DAY_IDX     = 3,
  parameter int          RST_EN_BIT  = 4,
  parameter int          OSC_OFF_BIT = 5,
  parameter logic [63:0] KEY         = 64'h5CA33AC55CA33AC5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic acc_i,
  input  logic rd_i,
  input  logic data_i,
  input  logic rst_pin_ni,
  input  logic tick_i,
  output logic dout_o,
  output logic dout_en_o
);
  localparam int TOT = NUM_REGS * REG_W;

  logic           pin_en_w, osc_on_w, abort_w;
  logic           match_en_w, done_w;
  logic           busy_w, rd_mode_w, shift_w, last_w, commit_w;
  logic           snap_bit_w;
  logic [TOT-1:0] regs_w;

  assign abort_w    = pin_en_w & ~rst_pin_ni;
  assign match_en_w = acc_i & ~busy_w & ~abort_w;
  assign commit_w   = last_w & ~rd_mode_w & ~abort_w;
  assign dout_en_o  = busy_w & rd_mode_w;
  assign dout_o     = dout_en_o & snap_bit_w;

  scp_matcher #(.KEY_W(64), .KEY(KEY)) u_match (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (abort_w),
    .en_i   (match_en_w),
    .rd_i   (rd_i),
    .bit_i  (data_i),
    .done_o (done_w)
  );

  scp_sequencer #(.XFER_BITS(TOT)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (abort_w),
    .start_i   (done_w),
    .acc_i     (acc_i & ~abort_w),
    .rd_i      (rd_i),
    .busy_o    (busy_w),
    .rd_mode_o (rd_mode_w),
    .shift_o   (shift_w),
    .last_o    (last_w)
  );

  scp_regfile #(
    .NUM_REGS(NUM_REGS), .REG_W(REG_W), .DAY_IDX(DAY_IDX),
    .RST_EN_BIT(RST_EN_BIT), .OSC_OFF_BIT(OSC_OFF_BIT)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (done_w),
    .shift_i   (shift_w),
    .rd_mode_i (rd_mode_w),
    .bit_i     (data_i),
    .commit_i  (commit_w),
    .tick_i    (tick_i),
    .dout_o    (snap_bit_w),
    .pin_en_o  (pin_en_w),
    .osc_on_o  (osc_on_w),
    .regs_o    (regs_w)
  );
endmodule

// File: rtl/scp_checker.sv
module scp_checker #(
  parameter int TOT = 64
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           tick_i,
  input logic           busy_i,
  input logic           abort_i,
  input logic           done_i,
  input logic           last_i,
  input logic           commit_i,
  input logic           osc_on_i,
  input logic           dout_en_i,
  input logic [TOT-1:0] regs_i
);
  // R2
  unlock_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> busy_i);

  // R4
  regs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit_i && !tick_i) |=> $stable(regs_i));

  // R4
  commit_in_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> busy_i);

  // R6
  xfer_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_i |=> !busy_i);

  // R6
  dout_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_en_i |-> busy_i);

  // R7
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (!busy_i && $stable(regs_i)));

  // R10
  osc_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!osc_on_i && !commit_i) |=> $stable(regs_i));
endmodule

bind serial_clock_port scp_checker #(.TOT(NUM_REGS*REG_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .busy_i    (busy_w),
  .abort_i   (abort_w),
  .done_i    (done_w),
  .last_i    (last_w),
  .commit_i  (commit_w),
  .osc_on_i  (osc_on_w),
  .dout_en_i (dout_en_o),
  .regs_i    (regs_w)
);

// File: tb/sim_serial_clock_port.sv
module sim_serial_clock_port;
  localparam int          CLK_PERIOD = 10;
  localparam logic [63:0] UKEY       = 64'h5CA33AC55CA33AC5;
  localparam logic [63:0] RST_IMG    = 64'h20 << 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc = 1'b0, rd = 1'b0, din = 1'b0, pin_n = 1'b1, tick = 1'b0;
  logic dout, dout_en;
  int   checks = 0, fails = 0;
  logic en_all;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_clock_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .acc_i(acc), .rd_i(rd), .data_i(din),
    .rst_pin_ni(pin_n), .tick_i(tick), .dout_o(dout), .dout_en_o(dout_en)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic r, input logic d, output logic q, output logic e);
    @(negedge clk);
    acc = 1'b1; rd = r; din = d;
    #1;
    q = dout; e = dout_en;
    @(negedge clk);
    acc = 1'b0;
  endtask

  task automatic pulse_pin();
    @(negedge clk); pin_n = 1'b0;
    @(negedge clk); pin_n = 1'b1;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic send_key(input int n, input int flip_at);
    logic q, e;
    for (int k = 0; k < n; k++) access(1'b0, UKEY[k] ^ (k == flip_at), q, e);
  endtask

  task automatic send_zeros(input int n);
    logic q, e;
    for (int k = 0; k < n; k++) access(1'b0, 1'b0, q, e);
  endtask

  task automatic write_image(input logic [63:0] v, input int pin_at, input bit mixed);
    logic q, e;
    send_key(64, -1);
    for (int k = 0; k < 64; k++) begin
      if (k == pin_at) pulse_pin();
      access(mixed && (k > 0), v[k], q, e);
    end
  endtask

  task automatic read_image(output logic [63:0] img, input int pin_at, input int tick_at,
                            input bit mixed);
    logic q, e;
    send_key(64, -1);
    en_all = 1'b1;
    for (int k = 0; k < 64; k++) begin
      if (k == pin_at) pulse_pin();
      if (k == tick_at) pulse_tick();
      access((k == 0) || !mixed, mixed, q, e);
      img[k] = q;
      en_all &= e;
    end
  endtask

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [63:0] mk_img(input logic [7:0] s, input logic [7:0] m,
                                         input logic [7:0] day);
    return {8'hA5, 8'h24, 8'h06, 8'h15, day, 8'h07, m, s};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] img, exp_img;
    logic q, e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R3: reset image read out
    read_image(img, -1, -1, 0);
    chk("R1 reset image", img, RST_IMG);
    chk("R3 dout_en through read", 64'(en_all), 64'h1);

    // R10: oscillator off at reset, ticks ignored
    repeat (5) pulse_tick();
    read_image(img, -1, -1, 0);
    chk("R10 ticks frozen", img, RST_IMG);

    // R4: write full image, osc on
    exp_img = mk_img(8'h58, 8'h12, 8'h00);
    write_image(exp_img, -1, 0);
    read_image(img, -1, -1, 0);
    chk("R4 write readback", img, exp_img);

    // R9: tick and carry
    pulse_tick();
    read_image(img, -1, -1, 0);
    chk("R9 tick 58->59", img, mk_img(8'h59, 8'h12, 8'h00));
    pulse_tick();
    read_image(img, -1, -1, 0);
    chk("R9 carry to minutes", img, mk_img(8'h00, 8'h13, 8'h00));

    // R3: tick mid-read does not tear the snapshot
    read_image(img, -1, 10, 0);
    chk("R3 snapshot vs tick", img, mk_img(8'h00, 8'h13, 8'h00));
    read_image(img, -1, -1, 0);
    chk("R3 tick applied after", img, mk_img(8'h01, 8'h13, 8'h00));

    // R5: read direction latched, later writes ignored
    exp_img = mk_img(8'h01, 8'h13, 8'h00);
    read_image(img, -1, -1, 1);
    chk("R5 mixed read data", img, exp_img);
    read_image(img, -1, -1, 0);
    chk("R5 mixed read no write", img, exp_img);

    // R5: write direction latched, later read selects ignored
    exp_img = mk_img(8'h33, 8'h44, 8'h00);
    write_image(exp_img, -1, 1);
    read_image(img, -1, -1, 0);
    chk("R5 mixed write commit", img, exp_img);

    // R6: no read data after the 64th access
    access(1'b1, 1'b0, q, e);
    chk("R6 dout_en after transfer", 64'(e), 64'h0);
    send_zeros(64);

    // R2: corrupted key does not unlock
    send_key(64, 40);
    send_zeros(64);
    send_zeros(64);
    read_image(img, -1, -1, 0);
    chk("R2 bad key ignored", img, exp_img);

    // R2: read access during key restarts matching
    send_key(10, -1);
    access(1'b1, 1'b0, q, e);
    for (int k = 10; k < 64; k++) access(1'b0, UKEY[k], q, e);
    send_zeros(64);
    send_zeros(64);
    read_image(img, -1, -1, 0);
    chk("R2 read breaks key", img, exp_img);

    // R7: abort mid-write leaves registers unchanged
    send_key(64, -1);
    for (int k = 0; k < 30; k++) access(1'b0, 1'b1, q, e);
    pulse_pin();
    send_zeros(34);
    send_zeros(64);
    read_image(img, -1, -1, 0);
    chk("R7 abort in write", img, exp_img);

    // R7: abort mid-key, full key afterwards unlocks from bit 0
    send_key(20, -1);
    pulse_pin();
    read_image(img, -1, -1, 0);
    chk("R7 restart after abort", img, exp_img);
    chk("R7 restart dout_en", 64'(en_all), 64'h1);

    // R7: abort mid-write near the end
    write_image(mk_img(8'h00, 8'h00, 8'h00), 63, 0);
    send_zeros(64);
    read_image(img, -1, -1, 0);
    chk("R7 late abort", img, exp_img);

    // R8: pin ignored when day bit 4 set
    exp_img = mk_img(8'h30, 8'h20, 8'h10);
    write_image(exp_img, -1, 0);
    read_image(img, 20, -1, 0);
    chk("R8 read with pin low", img, exp_img);
    exp_img = mk_img(8'h31, 8'h21, 8'h10);
    write_image(exp_img, 30, 0);
    read_image(img, -1, -1, 0);
    chk("R8 write with pin low", img, exp_img);

    // R9: sweep through wraps from 00:58
    write_image(mk_img(8'h00, 8'h58, 8'h00), -1, 0);
    for (int n = 1; n <= 130; n++) begin
      pulse_tick();
      read_image(img, -1, -1, 0);
      chk("R9 sweep", img, mk_img(bcd(n % 60), bcd((58 + n / 60) % 60), 8'h00));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule